// File: doc/BRIEF.md
# Two-Wire EEPROM Target Engine

This block is the bus-facing protocol engine of a 512-byte serial EEPROM. It watches an oversampled clock/data pair from a two-wire bus (I2C-style), finds the START and STOP conditions, and collects the control byte. The block answers only when three things hold: the control byte carries the fixed device code, the two chip-select bits agree with the strap pins, and no internal programming cycle is running. It drives the bus through a single pull-down enable. The data line is the wired-AND of the master and this pull-down.

In a write transaction the byte after the control byte sets the word pointer. Each later byte is handed to a page buffer with its address. The pointer advances inside a 16-byte page. A STOP that closes a write with at least one data byte raises a one-cycle commit strobe, which starts the programming cycle. In a read transaction the engine fetches bytes from the array at its pointer and shifts them out MSB first. It stops driving when the master declines to acknowledge. The memory array, the programming timer and the analog bus conditioning sit outside this block.

Top module: `ee_target_engine`

## Requirements
- R1: Both bus inputs pass through a two-flop synchroniser. SDA falling while SCL is high is a START, which opens a new control-byte phase with the pull-down released. SDA rising while SCL is high is a STOP, which returns the engine to idle with the pull-down released. After reset the pull-down, the write strobe and the commit strobe are all low.
- R2: The control byte is taken MSB first. Bits 7..4 must equal 1010 and bits 3..2 must equal `strap_i[1:0]`. Bit 1 has no part in selection. Bit 0 is the direction: 1 means read, 0 means write. On a match the engine pulls SDA low for the whole high phase of the ninth clock. On a mismatch it does not drive SDA again until the next START.
- R3: While `busy_i` is high, a control byte that otherwise matches gets no acknowledge, and the engine stays silent until the next START.
- R4: In a write, bit 1 of the control byte becomes pointer bit 8, and the next byte becomes pointer bits 7..0. That byte is acknowledged.
- R5: Each write data byte is acknowledged. It produces a one-cycle `wr_valid_o` pulse carrying the current pointer and the byte. After it the pointer's low 4 bits increment modulo 16 and bits 8..4 are held.
- R6: In a read, bit 1 of the control byte sets pointer bit 8. Each byte sent is `rd_data_i` as presented at `rd_addr_o`, shifted MSB first. The full 9-bit pointer increments by one after each byte is loaded, wrapping from 0x1FF to 0x000.
- R7: After a sent byte, a low SDA in the ninth clock (master acknowledge) makes the engine send the next byte. A high SDA (no acknowledge) makes it release SDA and stay off the bus until the next START.
- R8: A STOP raises `commit_o` for one cycle only if at least one write data byte has been taken since the last START. A STOP that ends a read, an address-only write or an unanswered transaction raises nothing.
- R9: A START or STOP that arrives part-way through a byte abandons that byte. No write strobe is produced for it. After such a START a fresh control byte is accepted.
- R10: The pull-down enable changes only while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling system clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock as seen on the pin |
| sda_i | input | 1 | Bus data as seen on the pin (wired-AND value) |
| strap_i | input | 2 | Chip-select strap pins compared with control bits 3..2 |
| busy_i | input | 1 | High while the internal programming cycle runs |
| rd_data_i | input | 8 | Array byte at `rd_addr_o` |
| sda_pull_o | output | 1 | Open-drain pull-down enable for SDA |
| rd_addr_o | output | 9 | Current word pointer, used as the array read address |
| wr_valid_o | output | 1 | One-cycle strobe for a received data byte |
| wr_addr_o | output | 9 | Address of the strobed data byte |
| wr_data_o | output | 8 | Strobed data byte |
| commit_o | output | 1 | One-cycle strobe that starts the programming cycle |

## Verification
Writes are tried with a run of three bytes that crosses the end of a 16-byte page. The expected addresses 0x03E, 0x03F, 0x030 separate page-local wrapping from a plain increment. Reading that region back with a pointer that walks on to 0x040, and a second read that runs from 0x1FF to 0x000, separate the full-pointer increment used by reads from the page increment used by writes. Random reads with control bit 1 set confirm that bit 8 of the address comes from the control byte and not from the strap comparison. Control bytes with the wrong code, the wrong strap value or a busy array show the difference between selection failure and a refused acknowledge. A START or STOP placed after a few bits of a data byte shows that partial bytes leave no write strobe and no commit, and that a following write still lands.

// File: rtl/ee_tgt_pkg.sv
package ee_tgt_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = BYTE_W + 1;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_RX_ACK,
        ST_TX,
        ST_TX_ACK
    } eng_state_e;

    typedef enum logic [1:0] {
        PH_CTRL,
        PH_WADDR,
        PH_WDATA
    } rx_phase_e;

    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

    // Device-code and strap comparison; bit 1 of the byte is left out on purpose.
    function automatic logic ctrl_match(input logic [BYTE_W-1:0] b,
                                        input logic [3:0]        code,
                                        input logic [1:0]        strap);
        return (b[7:4] == code) && (b[3:2] == strap);
    endfunction

    // Increment inside a page of 2**pb bytes, keeping the upper bits.
    function automatic logic [ADDR_W-1:0] page_inc(input logic [ADDR_W-1:0] a,
                                                   input int                pb);
        logic [ADDR_W-1:0] mask;
        mask = ADDR_W'((1 << pb) - 1);
        return (a & ~mask) | ((a + ADDR_W'(1)) & mask);
    endfunction

endpackage

// File: rtl/ee_bus_sampler.sv
module ee_bus_sampler
    import ee_tgt_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev_o
);

    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stg
        logic scl_r;
        logic sda_r;
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_r <= 1'b1;
                    sda_r <= 1'b1;
                end else begin
                    scl_r <= scl_i;
                    sda_r <= sda_i;
                end
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_r <= 1'b1;
                    sda_r <= 1'b1;
                end else begin
                    scl_r <= g_stg[i-1].scl_r;
                    sda_r <= g_stg[i-1].sda_r;
                end
            end
        end
    end

    logic scl_s, sda_s, scl_p, sda_p;
    assign scl_s = g_stg[SYNC_STAGES-1].scl_r;
    assign sda_s = g_stg[SYNC_STAGES-1].sda_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_s;
            sda_p <= sda_s;
        end
    end

    always_comb begin
        ev_o.scl      = scl_s;
        ev_o.sda      = sda_s;
        ev_o.scl_rise = scl_s & ~scl_p;
        ev_o.scl_fall = ~scl_s & scl_p;
        ev_o.start    = scl_s & scl_p & sda_p & ~sda_s;
        ev_o.stop     = scl_s & scl_p & ~sda_p & sda_s;
    end

endmodule

// File: rtl/ee_shift_unit.sv
module ee_shift_unit #(
    parameter  int W  = 8,
    localparam int CW = $clog2(W + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [W-1:0]  load_val,
    input  logic          clear,
    input  logic          count,
    input  logic          shift,
    input  logic          shift_bit,
    output logic [W-1:0]  data_o,
    output logic [CW-1:0] cnt_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            data_o <= '0;
            cnt_o  <= '0;
        end else if (load) begin
            data_o <= load_val;
            cnt_o  <= '0;
        end else begin
            if (clear)
                cnt_o <= '0;
            else if (count)
                cnt_o <= cnt_o + CW'(1);
            if (shift)
                data_o <= {data_o[W-2:0], shift_bit};
        end
    end

    // R9
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        (count && !clear && !load) |=> (cnt_o <= CW'(W)));

endmodule

// File: rtl/ee_target_engine.sv
module ee_target_engine
    import ee_tgt_pkg::*;
#(
    parameter int         SYNC_STAGES = 2,
    parameter int         PAGE_BITS   = 4,
    parameter logic [3:0] DEV_CODE    = 4'b1010
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [1:0]        strap_i,
    input  logic              busy_i,
    input  logic [BYTE_W-1:0] rd_data_i,
    output logic              sda_pull_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    output logic              wr_valid_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [BYTE_W-1:0] wr_data_o,
    output logic              commit_o
);

    bus_ev_t           ev;
    eng_state_e        st_q;
    rx_phase_e         ph_q;
    logic [ADDR_W-1:0] ptr_q;
    logic              pull_q, rd_mode_q, mack_q, wrote_q, commit_q, wr_valid_q;
    logic [ADDR_W-1:0] wr_addr_q;
    logic [BYTE_W-1:0] wr_data_q;
    logic [BYTE_W-1:0] sh_data;
    logic [CNT_W-1:0]  sh_cnt;

    ee_bus_sampler #(.SYNC_STAGES(SYNC_STAGES)) sampler_i (
        .clk  (clk),
        .rst  (rst),
        .scl_i(scl_i),
        .sda_i(sda_i),
        .ev_o (ev)
    );

    logic bit_last, byte_end, ack_end, tx_next, tx_load, tx_step;
    logic sh_shift, sh_bit, sh_count, sh_clear, ctrl_ok;

    always_comb begin
        bit_last = (sh_cnt == CNT_W'(BYTE_W));
        byte_end = (st_q == ST_RX) && ev.scl_fall && bit_last;
        ack_end  = (st_q == ST_RX_ACK) && ev.scl_fall;
        tx_next  = (st_q == ST_TX_ACK) && ev.scl_fall && mack_q;
        tx_load  = !ev.start && !ev.stop && ((ack_end && rd_mode_q) || tx_next);
        tx_step  = (st_q == ST_TX) && ev.scl_fall && !bit_last;
        sh_shift = ((st_q == ST_RX) && ev.scl_rise) || tx_step;
        sh_bit   = (st_q == ST_TX) ? 1'b1 : ev.sda;
        sh_count = ((st_q == ST_RX) || (st_q == ST_TX)) && ev.scl_rise;
        sh_clear = ev.start || ack_end;
        ctrl_ok  = ctrl_match(sh_data, DEV_CODE, strap_i) && !busy_i;
    end

    ee_shift_unit #(.W(BYTE_W)) shifter_i (
        .clk      (clk),
        .rst      (rst),
        .load     (tx_load),
        .load_val (rd_data_i),
        .clear    (sh_clear),
        .count    (sh_count),
        .shift    (sh_shift),
        .shift_bit(sh_bit),
        .data_o   (sh_data),
        .cnt_o    (sh_cnt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= ST_IDLE;
            ph_q       <= PH_CTRL;
            ptr_q      <= '0;
            pull_q     <= 1'b0;
            rd_mode_q  <= 1'b0;
            mack_q     <= 1'b0;
            wrote_q    <= 1'b0;
            commit_q   <= 1'b0;
            wr_valid_q <= 1'b0;
            wr_addr_q  <= '0;
            wr_data_q  <= '0;
        end else begin
            wr_valid_q <= 1'b0;
            commit_q   <= 1'b0;
            if (ev.start) begin
                st_q      <= ST_RX;
                ph_q      <= PH_CTRL;
                pull_q    <= 1'b0;
                rd_mode_q <= 1'b0;
                wrote_q   <= 1'b0;
            end else if (ev.stop) begin
                st_q      <= ST_IDLE;
                pull_q    <= 1'b0;
                rd_mode_q <= 1'b0;
                commit_q  <= wrote_q;
                wrote_q   <= 1'b0;
            end else begin
                unique case (st_q)
                    ST_RX: if (byte_end) begin
                        unique case (ph_q)
                            PH_CTRL: begin
                                if (ctrl_ok) begin
                                    pull_q            <= 1'b1;
                                    st_q              <= ST_RX_ACK;
                                    rd_mode_q         <= sh_data[0];
                                    ptr_q[ADDR_W-1]   <= sh_data[1];
                                end else begin
                                    st_q <= ST_IDLE;
                                end
                            end
                            PH_WADDR: begin
                                ptr_q[BYTE_W-1:0] <= sh_data;
                                pull_q            <= 1'b1;
                                st_q              <= ST_RX_ACK;
                            end
                            default: begin
                                wr_valid_q <= 1'b1;
                                wr_addr_q  <= ptr_q;
                                wr_data_q  <= sh_data;
                                ptr_q      <= page_inc(ptr_q, PAGE_BITS);
                                wrote_q    <= 1'b1;
                                pull_q     <= 1'b1;
                                st_q       <= ST_RX_ACK;
                            end
                        endcase
                    end
                    ST_RX_ACK: if (ev.scl_fall) begin
                        if (rd_mode_q) begin
                            st_q   <= ST_TX;
                            pull_q <= ~rd_data_i[BYTE_W-1];
                            ptr_q  <= ptr_q + ADDR_W'(1);
                        end else begin
                            st_q   <= ST_RX;
                            pull_q <= 1'b0;
                            ph_q   <= (ph_q == PH_CTRL) ? PH_WADDR : PH_WDATA;
                        end
                    end
                    ST_TX: if (ev.scl_fall) begin
                        if (bit_last) begin
                            pull_q <= 1'b0;
                            st_q   <= ST_TX_ACK;
                        end else begin
                            pull_q <= ~sh_data[BYTE_W-2];
                        end
                    end
                    ST_TX_ACK: begin
                        if (ev.scl_rise)
                            mack_q <= ~ev.sda;
                        if (ev.scl_fall) begin
                            if (mack_q) begin
                                st_q   <= ST_TX;
                                pull_q <= ~rd_data_i[BYTE_W-1];
                                ptr_q  <= ptr_q + ADDR_W'(1);
                            end else begin
                                st_q <= ST_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign sda_pull_o = pull_q;
    assign rd_addr_o  = ptr_q;
    assign wr_valid_o = wr_valid_q;
    assign wr_addr_o  = wr_addr_q;
    assign wr_data_o  = wr_data_q;
    assign commit_o   = commit_q;

    // R10
    pull_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
        (!$stable(pull_q) && !$past(ev.start) && !$past(ev.stop)) |-> !$past(ev.scl));

    // R1
    stop_idle_chk: assert property (@(posedge clk) disable iff (rst)
        ev.stop |=> (st_q == ST_IDLE && !sda_pull_o));

    // R3
    busy_noack_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_RX && ph_q == PH_CTRL && busy_i) |=> !sda_pull_o);

    // R5
    page_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        wr_valid_o |-> ((rd_addr_o[ADDR_W-1:PAGE_BITS] == wr_addr_o[ADDR_W-1:PAGE_BITS]) &&
                        (rd_addr_o[PAGE_BITS-1:0] ==
                         PAGE_BITS'(wr_addr_o[PAGE_BITS-1:0] + PAGE_BITS'(1)))));

    // R7
    nack_release_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_TX_ACK && ev.scl_fall && !mack_q && !ev.start && !ev.stop)
            |=> (st_q == ST_IDLE && !sda_pull_o));

    // R8
    commit_after_stop_chk: assert property (@(posedge clk) disable iff (rst)
        commit_o |-> $past(ev.stop));

endmodule

// File: tb/ee_target_engine_tb.sv
module ee_target_engine_tb_top;

    localparam int   Q     = 8;
    localparam logic [1:0] STRAP = 2'b10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       busy = 1'b0;
    logic       sda_bus;
    logic [7:0] rd_data;
    logic       sda_pull_o, wr_valid_o, commit_o;
    logic [8:0] rd_addr_o, wr_addr_o;
    logic [7:0] wr_data_o;

    always #2.5 clk = ~clk;

    assign sda_bus = sda_m & ~sda_pull_o;

    ee_target_engine dut_i (
        .clk       (clk),
        .rst       (rst),
        .scl_i     (scl_m),
        .sda_i     (sda_bus),
        .strap_i   (STRAP),
        .busy_i    (busy),
        .rd_data_i (rd_data),
        .sda_pull_o(sda_pull_o),
        .rd_addr_o (rd_addr_o),
        .wr_valid_o(wr_valid_o),
        .wr_addr_o (wr_addr_o),
        .wr_data_o (wr_data_o),
        .commit_o  (commit_o)
    );

    // Array model outside the engine.
    logic [7:0] arr [512];
    assign rd_data = arr[rd_addr_o];
    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 512; i++) arr[i] <= 8'((i * 37 + 5) & 255);
        end else if (wr_valid_o) begin
            arr[wr_addr_o] <= wr_data_o;
        end
    end

    logic [7:0] ref_mem [512];

    typedef struct packed {
        logic [8:0] a;
        logic [7:0] d;
    } wexp_t;
    wexp_t wq [$];

    int checks = 0;
    int errors = 0;
    int commit_cnt = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Monitor: write scoreboard, commit count, R10 timing of the pull-down.
    logic prev_pull = 1'b0;
    always @(negedge clk) begin
        if (!rst) begin
            if (wr_valid_o) begin
                if (wq.size() == 0) begin
                    chk(1'b0, "R5", "unexpected write strobe addr", int'(wr_addr_o), 0);
                end else begin
                    wexp_t e;
                    e = wq.pop_front();
                    chk(wr_addr_o == e.a, "R5", "write address", int'(wr_addr_o), int'(e.a));
                    chk(wr_data_o == e.d, "R5", "write data", int'(wr_data_o), int'(e.d));
                end
            end
            if (commit_o) commit_cnt++;
            if (sda_pull_o != prev_pull && scl_m)
                chk(1'b0, "R10", "pull changed with SCL high", int'(sda_pull_o), int'(prev_pull));
            prev_pull = sda_pull_o;
        end
    end

    task automatic tick();
        repeat (Q) @(negedge clk);
        #1;
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick();
        scl_m = 1'b1; tick();
        sda_m = 1'b0; tick();
        scl_m = 1'b0; tick();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick();
        scl_m = 1'b1; tick();
        sda_m = 1'b1; tick();
        tick();
    endtask

    task automatic put_bit(input logic b);
        sda_m = b;    tick();
        scl_m = 1'b1; tick();
        tick();
        scl_m = 1'b0; tick();
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) put_bit(b[i]);
        sda_m = 1'b1; tick();
        scl_m = 1'b1; tick();
        ack = !sda_bus;
        tick();
        scl_m = 1'b0; tick();
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] v);
        sda_m = 1'b1;
        v = '0;
        for (int i = 0; i < 8; i++) begin
            tick();
            scl_m = 1'b1; tick();
            v = {v[6:0], sda_bus};
            tick();
            scl_m = 1'b0;
        end
        tick();
        sda_m = !give_ack; tick();
        scl_m = 1'b1; tick();
        tick();
        scl_m = 1'b0; tick();
        sda_m = 1'b1;
    endtask

    function automatic logic [7:0] cb(input logic [3:0] code, input logic [1:0] sel,
                                      input logic a0, input logic rw);
        return {code, sel, a0, rw};
    endfunction

    // Driver for one write data byte: predicts address, pushes expectation.
    task automatic drive_data(inout logic [8:0] p, input logic [7:0] d, input string req);
        bit ack;
        wq.push_back({p, d});
        ref_mem[p] = d;
        p = {p[8:4], 4'(p[3:0] + 4'd1)};
        send_byte(d, ack);
        chk(ack, req, "data byte ack", int'(ack), 1);
    endtask

    task automatic read_expect(input logic [8:0] p, input bit last, input string req);
        logic [7:0] v;
        recv_byte(!last, v);
        chk(v == ref_mem[p], req, "read byte", int'(v), int'(ref_mem[p]));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            errors++;
            $display("FAIL R1 watchdog: actual %0d cycles expected completion", 200000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        bit         ack;
        logic [8:0] p;
        int         cc;
        for (int i = 0; i < 512; i++) ref_mem[i] = 8'((i * 37 + 5) & 255);
        repeat (10) @(negedge clk);
        #1;
        // R1: reset state
        chk(sda_pull_o == 1'b0, "R1", "pull after reset", int'(sda_pull_o), 0);
        chk(wr_valid_o == 1'b0, "R1", "write strobe after reset", int'(wr_valid_o), 0);
        chk(commit_o == 1'b0, "R1", "commit after reset", int'(commit_o), 0);
        rst = 1'b0;
        tick();

        // Write across a page end: 03E, 03F, 030
        bus_start();
        send_byte(cb(4'b1010, STRAP, 1'b0, 1'b0), ack);
        chk(ack, "R2", "matching control ack", int'(ack), 1);
        send_byte(8'h3E, ack);
        chk(ack, "R4", "word address ack", int'(ack), 1);
        p = 9'h03E;
        drive_data(p, 8'hAA, "R5");
        drive_data(p, 8'hBB, "R5");
        drive_data(p, 8'hCC, "R5");
        bus_stop();
        chk(commit_cnt == 1, "R8", "commit after write stop", commit_cnt, 1);

        // Random read at 0x110 with control bit 1 set
        bus_start();
        send_byte(cb(4'b1010, STRAP, 1'b1, 1'b0), ack);
        chk(ack, "R2", "control ack with bit1 set", int'(ack), 1);
        send_byte(8'h10, ack);
        chk(ack, "R4", "address ack", int'(ack), 1);
        bus_start();
        send_byte(cb(4'b1010, STRAP, 1'b1, 1'b1), ack);
        chk(ack, "R6", "read control ack", int'(ack), 1);
        read_expect(9'h110, 1'b0, "R6");
        read_expect(9'h111, 1'b0, "R7");
        read_expect(9'h112, 1'b1, "R7");
        sda_m = 1'b1; tick();
        scl_m = 1'b1; tick();
        chk(sda_bus == 1'b1, "R7", "SDA released after master nack", int'(sda_bus), 1);
        tick();
        scl_m = 1'b0; tick();
        bus_stop();
        chk(commit_cnt == 1, "R8", "no commit after read", commit_cnt, 1);

        // Read back across the page end: pointer walks 03E, 03F, 040
        bus_start();
        send_byte(cb(4'b1010, STRAP, 1'b0, 1'b0), ack);
        send_byte(8'h3E, ack);
        bus_start();
        send_byte(cb(4'b1010, STRAP, 1'b0, 1'b1), ack);
        chk(ack, "R6", "read control ack", int'(ack), 1);
        read_expect(9'h03E, 1'b0, "R6");
        read_expect(9'h03F, 1'b0, "R6");
        read_expect(9'h040, 1'b1, "R6");
        bus_stop();
        chk(commit_cnt == 1, "R8", "no commit after address-only write", commit_cnt, 1);

        // Full pointer wrap 1FF -> 000
        bus_start();
        send_byte(cb(4'b1010, STRAP, 1'b1, 1'b0), ack);
        send_byte(8'hFF, ack);
        bus_start();
        send_byte(cb(4'b1010, STRAP, 1'b1, 1'b1), ack);
        read_expect(9'h1FF, 1'b0, "R6");
        read_expect(9'h000, 1'b1, "R6");
        bus_stop();

        // Busy: no ack, no write, no commit
        busy = 1'b1;
        bus_start();
        send_byte(cb(4'b1010, STRAP, 1'b0, 1'b0), ack);
        chk(!ack, "R3", "control ack while busy", int'(ack), 0);
        send_byte(8'h22, ack);
        chk(!ack, "R3", "silent after refused control", int'(ack), 0);
        bus_stop();
        chk(commit_cnt == 1, "R3", "no commit while busy", commit_cnt, 1);
        busy = 1'b0;

        // Selection failures
        bus_start();
        send_byte(cb(4'b1010, 2'b01, 1'b0, 1'b0), ack);
        chk(!ack, "R2", "strap mismatch ack", int'(ack), 0);
        bus_stop();
        bus_start();
        send_byte(cb(4'b1011, STRAP, 1'b0, 1'b0), ack);
        chk(!ack, "R2", "device code mismatch ack", int'(ack), 0);
        bus_stop();

        // START in the middle of a data byte
        bus_start();
        send_byte(cb(4'b1010, STRAP, 1'b0, 1'b0), ack);
        send_byte(8'h50, ack);
        for (int i = 0; i < 4; i++) put_bit(1'b1);
        bus_start();
        send_byte(cb(4'b1010, STRAP, 1'b0, 1'b0), ack);
        chk(ack, "R9", "control ack after abort", int'(ack), 1);
        send_byte(8'h51, ack);
        p = 9'h051;
        drive_data(p, 8'h77, "R9");
        bus_stop();
        chk(commit_cnt == 2, "R9", "commit after recovered write", commit_cnt, 2);

        // STOP in the middle of the first data byte
        cc = commit_cnt;
        bus_start();
        send_byte(cb(4'b1010, STRAP, 1'b0, 1'b0), ack);
        send_byte(8'h60, ack);
        put_bit(1'b0); put_bit(1'b1); put_bit(1'b0);
        bus_stop();
        chk(commit_cnt == cc, "R9", "no commit for partial byte", commit_cnt, cc);

        // Write landed in the array: read 0x051
        bus_start();
        send_byte(cb(4'b1010, STRAP, 1'b0, 1'b0), ack);
        send_byte(8'h51, ack);
        bus_start();
        send_byte(cb(4'b1010, STRAP, 1'b0, 1'b1), ack);
        read_expect(9'h051, 1'b1, "R5");
        bus_stop();

        chk(wq.size() == 0, "R5", "pending expected writes", wq.size(), 0);

        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule